// File: doc/BRIEF.md
# Programmable Horizontal Line Timing Generator

This block produces the two horizontal timing waveforms of a video line, a sync pulse and a blanking window, by counting pixel clocks along the line. A host writes the line length, the sync pulse width and the first and last active sample positions through a plain register write port (address, data, write strobe). Each waveform has its own polarity control. Eight timing pins are fed by a per-pin selector that picks one waveform or a constant low level.

In lock mode, a one-cycle synchronous reference strobe reloads the line counter with a programmable offset. This puts the sync leading edge at a chosen distance from the reference. In free-run mode the strobe is ignored and the counter wraps on its own. A new line length, sync width or active window is held in shadow registers and only goes live at the next line start, so a write in mid-line cannot cut a pulse short. The pins are plain level outputs. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `hline_timer`

## Requirements
- R1: After reset the counter is 0 and the line is 64 clocks long, with sync width 6 and active samples 12..59. Pin 0 carries sync active-low, pin 1 carries blanking active-high, and pins 2..7 drive 0.
- R2: In free-run mode the line counter advances by one each clock. On the clock where it is at or above (line total - 1) it returns to 0. The line total is at address 0.
- R3: Sync is asserted while the counter is below the sync width (address 1). A width of 0 gives no sync pulse.
- R4: Blanking is deasserted while active start (address 2) <= counter <= active end (address 3), and asserted at every other count.
- R5: At address 5, bit 0 set makes sync active-high and bit 1 set inverts blanking. A write changes the pins from the next clock.
- R6: The select register of pin p is at address 8+p, bits 2:0. Code 1 routes sync, code 2 routes blanking, and any other code drives 0. A write changes the pin from the next clock.
- R7: With lock mode on (address 6, bit 0), a reference strobe loads the counter with the offset (address 4) at that clock edge. An offset of 0 therefore makes sync start in the cycle right after the strobe. With lock mode off, the strobe has no effect.
- R8: Writes to addresses 0..3 take effect only at the next line start, which is a wrap to 0 or a lock reload. The current line keeps its old values until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (12) | Register write data |
| ref_strobe | input | 1 | One-cycle reference line pulse, synchronous to clk |
| tout | output | NPIN (8) | Timing output pins |

## Verification
A wrong line counter shows on the pins within one line: the sync and blanking edges drift from the counts the reference model predicts. A counter that wraps at the wrong point shows up at the first wrap. Live configuration that loads early or late changes pulse widths at a line start that should not have changed them, or fails to change them at one that should. A bad selector or polarity bit shows on the very next clock after the write. The per-clock comparison of all eight pins catches each of these in the first cycle where it differs.

// File: rtl/hline_pkg.sv
`timescale 1ns/1ps
package hline_pkg;
  // register addresses
  localparam int A_TOTAL  = 0;
  localparam int A_SYNC   = 1;
  localparam int A_AST    = 2;
  localparam int A_AEND   = 3;
  localparam int A_OFFS   = 4;
  localparam int A_POL    = 5;
  localparam int A_MODE   = 6;
  localparam int SEL_BASE = 8;

  // pin select codes
  localparam logic [2:0] SEL_OFF   = 3'd0;
  localparam logic [2:0] SEL_SYNC  = 3'd1;
  localparam logic [2:0] SEL_BLANK = 3'd2;

  typedef struct packed {
    logic lock;
    logic blank_inv;
    logic sync_hi;
  } ctl_t;
endpackage

// File: rtl/hline_regs.sv
`timescale 1ns/1ps
module hline_regs
  import hline_pkg::*;
#(
  parameter int CW = 12,
  parameter int NPIN = 8,
  parameter int AW = 4,
  parameter int RST_TOTAL = 64,
  parameter int RST_SYNC = 6,
  parameter int RST_AST = 12,
  parameter int RST_AEND = 59
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] sh_total,
  output logic [CW-1:0] sh_sync,
  output logic [CW-1:0] sh_ast,
  output logic [CW-1:0] sh_aend,
  output logic [CW-1:0] offs,
  output ctl_t          ctl,
  output logic [2:0]    sel [NPIN]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_total <= CW'(RST_TOTAL);
      sh_sync  <= CW'(RST_SYNC);
      sh_ast   <= CW'(RST_AST);
      sh_aend  <= CW'(RST_AEND);
      offs     <= '0;
      ctl      <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        A_TOTAL: sh_total <= wr_data;
        A_SYNC:  sh_sync  <= wr_data;
        A_AST:   sh_ast   <= wr_data;
        A_AEND:  sh_aend  <= wr_data;
        A_OFFS:  offs     <= wr_data;
        A_POL: begin
          ctl.sync_hi   <= wr_data[0];
          ctl.blank_inv <= wr_data[1];
        end
        A_MODE:  ctl.lock <= wr_data[0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_sel
    localparam logic [2:0] RST_SEL = (p == 0) ? SEL_SYNC :
                                     (p == 1) ? SEL_BLANK : SEL_OFF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel[p] <= RST_SEL;
      else if (wr_en && (int'(wr_addr) == SEL_BASE + p))
        sel[p] <= wr_data[2:0];
    end
  end
endmodule

// File: rtl/hline_counter.sv
`timescale 1ns/1ps
module hline_counter #(
  parameter int CW = 12,
  parameter int RST_TOTAL = 64,
  parameter int RST_SYNC = 6,
  parameter int RST_AST = 12,
  parameter int RST_AEND = 59
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          ref_strobe,
  input  logic [CW-1:0] sh_total,
  input  logic [CW-1:0] sh_sync,
  input  logic [CW-1:0] sh_ast,
  input  logic [CW-1:0] sh_aend,
  input  logic [CW-1:0] offs,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cur_total,
  output logic [CW-1:0] cur_sync,
  output logic [CW-1:0] cur_ast,
  output logic [CW-1:0] cur_aend
);
  logic reload, wrap, line_start;

  assign reload     = lock && ref_strobe;
  assign wrap       = cnt >= (cur_total - CW'(1));
  assign line_start = reload || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= offs;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // live timing copies, refreshed only at a line start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_total <= CW'(RST_TOTAL);
      cur_sync  <= CW'(RST_SYNC);
      cur_ast   <= CW'(RST_AST);
      cur_aend  <= CW'(RST_AEND);
    end else if (line_start) begin
      cur_total <= sh_total;
      cur_sync  <= sh_sync;
      cur_ast   <= sh_ast;
      cur_aend  <= sh_aend;
    end
  end
endmodule

// File: rtl/hline_decode.sv
`timescale 1ns/1ps
module hline_decode #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cur_sync,
  input  logic [CW-1:0] cur_ast,
  input  logic [CW-1:0] cur_aend,
  output logic          sync_on,
  output logic          blank_on
);
  logic in_active;

  always_comb begin
    sync_on   = cnt < cur_sync;
    in_active = (cnt >= cur_ast) && (cnt <= cur_aend);
    blank_on  = !in_active;
  end
endmodule

// File: rtl/hline_pinmux.sv
`timescale 1ns/1ps
module hline_pinmux
  import hline_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            sync_on,
  input  logic            blank_on,
  input  ctl_t            ctl,
  input  logic [2:0]      sel [NPIN],
  output logic [NPIN-1:0] tout
);
  logic sync_lvl, blank_lvl;

  assign sync_lvl  = ctl.sync_hi ? sync_on : !sync_on;
  assign blank_lvl = ctl.blank_inv ? !blank_on : blank_on;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_comb begin
      case (sel[p])
        SEL_SYNC:  tout[p] = sync_lvl;
        SEL_BLANK: tout[p] = blank_lvl;
        default:   tout[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/hline_timer.sv
`timescale 1ns/1ps
module hline_timer
  import hline_pkg::*;
#(
  parameter int CW = 12,
  parameter int NPIN = 8,
  parameter int RST_TOTAL = 64,
  parameter int RST_SYNC = 6,
  parameter int RST_AST = 12,
  parameter int RST_AEND = 59,
  localparam int AW = $clog2(SEL_BASE + NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            ref_strobe,
  output logic [NPIN-1:0] tout
);
  logic [CW-1:0] sh_total, sh_sync, sh_ast, sh_aend, offs;
  logic [CW-1:0] cnt, cur_total, cur_sync, cur_ast, cur_aend;
  ctl_t          ctl;
  logic [2:0]    sel [NPIN];
  logic          sync_on, blank_on;

  hline_regs #(
    .CW(CW), .NPIN(NPIN), .AW(AW), .RST_TOTAL(RST_TOTAL),
    .RST_SYNC(RST_SYNC), .RST_AST(RST_AST), .RST_AEND(RST_AEND)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sh_total(sh_total), .sh_sync(sh_sync),
    .sh_ast(sh_ast), .sh_aend(sh_aend), .offs(offs), .ctl(ctl), .sel(sel)
  );

  hline_counter #(
    .CW(CW), .RST_TOTAL(RST_TOTAL), .RST_SYNC(RST_SYNC),
    .RST_AST(RST_AST), .RST_AEND(RST_AEND)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .lock(ctl.lock), .ref_strobe(ref_strobe),
    .sh_total(sh_total), .sh_sync(sh_sync), .sh_ast(sh_ast),
    .sh_aend(sh_aend), .offs(offs), .cnt(cnt), .cur_total(cur_total),
    .cur_sync(cur_sync), .cur_ast(cur_ast), .cur_aend(cur_aend)
  );

  hline_decode #(.CW(CW)) u_dec (
    .cnt(cnt), .cur_sync(cur_sync), .cur_ast(cur_ast), .cur_aend(cur_aend),
    .sync_on(sync_on), .blank_on(blank_on)
  );

  hline_pinmux #(.NPIN(NPIN)) u_mux (
    .sync_on(sync_on), .blank_on(blank_on), .ctl(ctl), .sel(sel), .tout(tout)
  );
endmodule

// File: rtl/hline_timer_chk.sv
`timescale 1ns/1ps
module hline_timer_chk #(
  parameter int CW = 12,
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lock,
  input logic            ref_strobe,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   cur_total,
  input logic [CW-1:0]   cur_sync,
  input logic [CW-1:0]   offs,
  input logic [2:0]      sel [NPIN],
  input logic [NPIN-1:0] tout
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lock && ref_strobe) && (cnt < cur_total - CW'(1)))
      |=> (cnt == CW'($past(cnt) + CW'(1))));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lock && ref_strobe) && (cnt >= cur_total - CW'(1)))
      |=> (cnt == '0));

  a_r7_lock_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ref_strobe) |=> (cnt == $past(offs)));

  a_r8_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lock && ref_strobe) && (cnt < cur_total - CW'(1)))
      |=> ($stable(cur_total) && $stable(cur_sync)));

  // R6: pins with no routed signal stay low
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NPIN; p++) begin
        if (sel[p] != 3'd1 && sel[p] != 3'd2)
          a_r6_idle_pin_low: assert (tout[p] == 1'b0);
      end
    end
  end
endmodule

bind hline_timer hline_timer_chk #(.CW(CW), .NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(ctl.lock), .ref_strobe(ref_strobe),
  .cnt(cnt), .cur_total(cur_total), .cur_sync(cur_sync), .offs(offs),
  .sel(sel), .tout(tout)
);

// File: tb/hline_timer_test.sv
`timescale 1ns/1ps
module hline_timer_test;
  localparam int CLK_P = 10;
  localparam int CW = 12;
  localparam int NPIN = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic ref_strobe = 1'b0;
  logic [NPIN-1:0] tout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, c_total, c_sync, c_ast, c_aend;
  int s_total, s_sync, s_ast, s_aend, m_offs;
  bit m_shi, m_binv, m_lock;
  int m_sel [NPIN];

  always #(CLK_P/2) clk = ~clk;

  hline_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ref_strobe(ref_strobe), .tout(tout)
  );

  task automatic model_reset();
    m_cnt = 0;
    c_total = 64; c_sync = 6; c_ast = 12; c_aend = 59;
    s_total = 64; s_sync = 6; s_ast = 12; s_aend = 59;
    m_offs = 0; m_shi = 0; m_binv = 0; m_lock = 0;
    for (int p = 0; p < NPIN; p++) m_sel[p] = (p == 0) ? 1 : (p == 1) ? 2 : 0;
  endtask

  function automatic logic [NPIN-1:0] expect_pins();
    logic [NPIN-1:0] e;
    bit s, b;
    s = m_cnt < c_sync;
    b = !((m_cnt >= c_ast) && (m_cnt <= c_aend));
    for (int p = 0; p < NPIN; p++) begin
      case (m_sel[p])
        1: e[p] = m_shi ? s : !s;
        2: e[p] = m_binv ? !b : b;
        default: e[p] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic compare();
    logic [NPIN-1:0] e;
    e = expect_pins();
    n_cmp++;
    if (tout !== e) begin
      n_bad++;
      $display("FAIL %s at count %0d: actual=%b expected=%b", tag, m_cnt, tout, e);
    end
  endtask

  task automatic tick(input bit we, input int a, input int d, input bit rs);
    bit reload, wrap;
    wr_en = we; wr_addr = AW'(a); wr_data = CW'(d); ref_strobe = rs;
    @(posedge clk);
    reload = m_lock && rs;
    wrap = m_cnt >= c_total - 1;
    if (reload || wrap) begin
      m_cnt = reload ? m_offs : 0;
      c_total = s_total; c_sync = s_sync; c_ast = s_ast; c_aend = s_aend;
    end else begin
      m_cnt++;
    end
    if (we) begin
      case (a)
        0: s_total = d;
        1: s_sync = d;
        2: s_ast = d;
        3: s_aend = d;
        4: m_offs = d;
        5: begin m_shi = d[0]; m_binv = d[1]; end
        6: m_lock = d[0];
        default: if (a >= 8 && a < 8 + NPIN) m_sel[a-8] = d & 7;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; ref_strobe = 1'b0;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    tick(1, a, d, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();  // R1 reset state at count 0
    run(3);
    tag = "R2"; run(140);           // R2, R3, R4 default line over two wraps
    tag = "R8";
    run(10);
    wr(0, 20); wr(1, 3); wr(2, 5); wr(3, 15);  // mid-line: must wait for wrap
    run(100);
    tag = "R5";
    wr(5, 1); run(25);
    wr(5, 3); run(25);
    wr(5, 2); run(25);
    wr(5, 0); run(5);
    tag = "R6";
    wr(8 + 3, 2); wr(8 + 4, 1); wr(8 + 5, 7); wr(8 + 0, 0); wr(8 + 7, 3);
    run(30);
    wr(8 + 0, 1); run(5);
    tag = "R7";
    run(3);
    tick(0, 0, 0, 1); run(7);       // free-run: strobe ignored
    wr(4, 0); wr(6, 1); run(4);
    tick(0, 0, 0, 1); run(12);      // offset 0: sync right after strobe
    wr(4, 7); run(2);
    tick(0, 0, 0, 1); run(25);
    wr(4, 25); tick(0, 0, 0, 1); run(25);  // offset beyond line end
    tag = "R8";
    wr(1, 9); run(3); tick(0, 0, 0, 1); run(25);  // reload is a line start
    wr(6, 0);
    tag = "R3";
    wr(1, 0); run(45);              // no sync pulse
    tag = "R4";
    wr(2, 0); wr(3, 19); run(45);   // never blanked
    wr(2, 10); wr(3, 10); run(45);  // single active sample
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual=running expected=finished", tag);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule